// File: doc/BRIEF.md
# Pin-Level GPIO Port with Atomic Bit Aliases

This block is a 29-pin general-purpose I/O port with a small memory-mapped register file. It has an output-value register and a direction register. Each pin's driven level follows its output-value bit, and each pin's output enable follows its direction bit. Software can write either register directly. It can also use write-only alias addresses that set, clear or invert only the bits written as one. A single pin can therefore change with one bus write and no read-modify-write sequence. The live state of the pins is also readable: it passes through a two-flop synchronizer first.

The bus is a plain synchronous port with no handshake. Every cycle the block samples `bus_addr`, `bus_we` and `bus_wdata`. A write takes effect at that clock edge, so only one write can land per cycle. Reads have no side effects. They are registered, so `bus_rdata` shows, one cycle later, the value that the addressed location held before the edge. Bits 1:0 of the address are ignored. These are the byte offsets: value register 0x000 (read/write), direction register 0x080 (read/write), synchronized pin state 0x100 (read-only), value set 0x200, value clear 0x280, value invert 0x300, direction set 0x380, direction clear 0x400, direction invert 0x480. The six aliases are write-only.

Top module: `gpio_port`

## Requirements
- R1: After reset the value and direction registers are zero, `pin_out` and `pin_oe` are all zero and `bus_rdata` is zero.
- R2: A write to offset 0x000 loads `bus_wdata[28:0]` into the value register, and `pin_out` shows it after that clock edge.
- R3: A write to offset 0x200 sets each value bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to offset 0x280 clears each value bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A write to offset 0x300 inverts each value bit whose write-data bit is 1 and leaves the others unchanged.
- R6: A write to offset 0x080 loads the direction register, and `pin_oe` shows it after that edge (1 = pin driven).
- R7: Writes to offsets 0x380, 0x400 and 0x480 set, clear and invert, in that order, the direction bits written as 1, and leave the other bits unchanged.
- R8: Reads of the six alias offsets and of unmapped offsets return zero. Writes to unmapped offsets and to the pin-state offset 0x100 change nothing. In a cycle with no write, `pin_out` and `pin_oe` hold.
- R9: `bus_rdata[31:29]` is always zero.
- R10: A level on `pin_in` captured at edge k is returned on `bus_rdata` after edge k+2 when offset 0x100 is addressed in the cycle before edge k+2.
- R11: `bus_rdata` is registered. When a read and a write target the same register in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 29 | Raw pin levels |
| pin_out | output | 29 | Driven pin values |
| pin_oe | output | 29 | Per-pin output enable |

## Verification
A read and a write to the same register can fall in the same cycle, because every cycle both decodes an address for readback and can perform a write. The bench provokes this with a write whose address is the value register itself. It judges the result by requiring the next `bus_rdata` to carry the value from before the write, with the new value appearing only on the following read. The pin synchronizer also runs alongside every register access. A random phase mixes pin changes, aliases and reads, and a behavioural model compares all three outputs on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // byte offsets of the register window (bits 1:0 ignored)
  localparam logic [31:0] OFF_VAL     = 32'h000;
  localparam logic [31:0] OFF_DIR     = 32'h080;
  localparam logic [31:0] OFF_PINS    = 32'h100;
  localparam logic [31:0] OFF_VAL_SET = 32'h200;
  localparam logic [31:0] OFF_VAL_CLR = 32'h280;
  localparam logic [31:0] OFF_VAL_INV = 32'h300;
  localparam logic [31:0] OFF_DIR_SET = 32'h380;
  localparam logic [31:0] OFF_DIR_CLR = 32'h400;
  localparam logic [31:0] OFF_DIR_INV = 32'h480;

  typedef enum logic [2:0] {
    BOP_HOLD,
    BOP_LOAD,
    BOP_SET,
    BOP_CLR,
    BOP_INV
  } bit_op_e;

  typedef enum logic [1:0] {
    RSEL_ZERO,
    RSEL_VAL,
    RSEL_DIR,
    RSEL_PINS
  } rd_sel_e;

  typedef struct packed {
    bit_op_e val_op;
    bit_op_e dir_op;
  } wr_ctl_t;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_ctl_t           wr,
  output rd_sel_e           rsel
);

  logic [31:0] word_addr;

  assign word_addr = 32'(addr) & ~32'h3;

  always_comb begin
    wr.val_op = BOP_HOLD;
    wr.dir_op = BOP_HOLD;
    rsel      = RSEL_ZERO;
    case (word_addr)
      OFF_VAL: begin
        rsel = RSEL_VAL;
        if (we) wr.val_op = BOP_LOAD;
      end
      OFF_DIR: begin
        rsel = RSEL_DIR;
        if (we) wr.dir_op = BOP_LOAD;
      end
      OFF_PINS:    rsel = RSEL_PINS;
      OFF_VAL_SET: if (we) wr.val_op = BOP_SET;
      OFF_VAL_CLR: if (we) wr.val_op = BOP_CLR;
      OFF_VAL_INV: if (we) wr.val_op = BOP_INV;
      OFF_DIR_SET: if (we) wr.dir_op = BOP_SET;
      OFF_DIR_CLR: if (we) wr.dir_op = BOP_CLR;
      OFF_DIR_INV: if (we) wr.dir_op = BOP_INV;
      default: ;
    endcase
  end

endmodule

// File: rtl/gpio_port_bitreg.sv
module gpio_port_bitreg
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bit_op_e          op,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      case (op)
        BOP_LOAD: q <= wd;
        BOP_SET:  q <= q | wd;
        BOP_CLR:  q <= q & ~wd;
        BOP_INV:  q <= q ^ wd;
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 29,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_N  = 29,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_N-1:0]  pin_in,
  output logic [PIN_N-1:0]  pin_out,
  output logic [PIN_N-1:0]  pin_oe
);

  localparam int unsigned PAD_W = DATA_W - PIN_N;

  wr_ctl_t          wr;
  rd_sel_e          rsel;
  logic [PIN_N-1:0] val_q;
  logic [PIN_N-1:0] dir_q;
  logic [PIN_N-1:0] pins_sync;
  logic [PIN_N-1:0] rd_pick;

  gpio_port_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .we   (bus_we),
    .wr   (wr),
    .rsel (rsel)
  );

  gpio_port_bitreg #(.WIDTH(PIN_N)) u_val (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (wr.val_op),
    .wd    (bus_wdata[PIN_N-1:0]),
    .q     (val_q)
  );

  gpio_port_bitreg #(.WIDTH(PIN_N)) u_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (wr.dir_op),
    .wd    (bus_wdata[PIN_N-1:0]),
    .q     (dir_q)
  );

  gpio_port_sync #(.WIDTH(PIN_N), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  always_comb begin
    case (rsel)
      RSEL_VAL:  rd_pick = val_q;
      RSEL_DIR:  rd_pick = dir_q;
      RSEL_PINS: rd_pick = pins_sync;
      default:   rd_pick = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= {{PAD_W{1'b0}}, rd_pick};
  end

  assign pin_out = val_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_N  = 29,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PIN_N-1:0]  pin_out,
  input logic [PIN_N-1:0]  pin_oe
);

  logic [31:0]      wa;
  logic [PIN_N-1:0] wbits;
  logic             alias_hit;

  assign wa    = 32'(bus_addr) & ~32'h3;
  assign wbits = bus_wdata[PIN_N-1:0];
  assign alias_hit = (wa == OFF_VAL_SET) || (wa == OFF_VAL_CLR) || (wa == OFF_VAL_INV) ||
                     (wa == OFF_DIR_SET) || (wa == OFF_DIR_CLR) || (wa == OFF_DIR_INV);

  assert_val_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wa == OFF_VAL_SET) |=> ((pin_out & $past(wbits)) == $past(wbits)));

  assert_val_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wa == OFF_VAL_CLR) |=> ((pin_out & $past(wbits)) == '0));

  assert_val_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wa == OFF_VAL_INV) |=> (pin_out == ($past(pin_out) ^ $past(wbits))));

  assert_dir_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wa == OFF_DIR_SET) |=> ((pin_oe & $past(wbits)) == $past(wbits)));

  assert_dir_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wa == OFF_DIR_CLR) |=> ((pin_oe & $past(wbits)) == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_alias_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alias_hit |=> (bus_rdata == '0));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PIN_N] == '0);

endmodule

bind gpio_port gpio_port_chk #(
  .PIN_N  (PIN_N),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_gpio_port_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

  localparam int PN = 29;
  localparam logic [31:0] MASK = 32'h1FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [PN-1:0] pin_in = '0;
  logic [PN-1:0] pin_out;
  logic [PN-1:0] pin_oe;

  int total = 0;
  int bad = 0;
  bit started = 0;
  string tag = "R1";

  // behavioural reference state
  logic [31:0] m_val = 0, m_dir = 0, m_rd = 0;
  logic [31:0] m_pipe [$];

  always #5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] model_read(logic [31:0] a);
    case (a & ~32'h3)
      32'h000: return m_val;
      32'h080: return m_dir;
      32'h100: return m_pipe[0];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] a, w;
    if (!rst_n) begin
      m_val = 0; m_dir = 0; m_rd = 0;
      m_pipe = '{32'h0, 32'h0};
    end else begin
      a = 32'(bus_addr);
      w = bus_wdata & MASK;
      m_rd = model_read(a);
      void'(m_pipe.pop_front());
      m_pipe.push_back(32'(pin_in));
      if (bus_we) begin
        case (a & ~32'h3)
          32'h000: m_val = w;
          32'h080: m_dir = w;
          32'h200: m_val = m_val | w;
          32'h280: m_val = m_val & ~w;
          32'h300: m_val = m_val ^ w;
          32'h380: m_dir = m_dir | w;
          32'h400: m_dir = m_dir & ~w;
          32'h480: m_dir = m_dir ^ w;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (started) begin
      check({tag, " rdata"}, bus_rdata, m_rd);
      check({tag, " pin_out"}, 32'(pin_out), m_val);
      check({tag, " pin_oe"}, 32'(pin_oe), m_dir);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    tag = "R1";
    check("R1 pin_out", 32'(pin_out), 0);
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 rdata", bus_rdata, 0);

    tag = "R2";
    wr(12'h000, 32'hF234_5678);
    check("R2 pin_out", 32'(pin_out), 32'h1234_5678);
    rd("R9 val read", 12'h000, 32'h1234_5678);
    tag = "R3";
    wr(12'h200, 32'h0000_00F0);
    rd("R3 set", 12'h000, 32'h1234_56F8);
    tag = "R4";
    wr(12'h280, 32'h1000_0001);
    rd("R4 clear", 12'h000, 32'h0234_56F8);
    tag = "R5";
    wr(12'h300, 32'hFFFF_FFFF);
    rd("R5 invert", 12'h000, 32'h1DCB_A907);

    tag = "R6";
    wr(12'h080, 32'h0000_FFFF);
    check("R6 pin_oe", 32'(pin_oe), 32'h0000_FFFF);
    tag = "R7";
    wr(12'h380, 32'h1F00_0000);
    rd("R7 dir set", 12'h080, 32'h1F00_FFFF);
    wr(12'h400, 32'h0000_00FF);
    rd("R7 dir clear", 12'h080, 32'h1F00_FF00);
    wr(12'h480, 32'hFFFF_0000);
    rd("R7 dir invert", 12'h080, 32'h00FF_FF00);

    tag = "R8";
    for (int i = 0; i < 6; i++) rd("R8 alias read", 12'(32'h200 + i * 32'h80), 0);
    rd("R8 unmapped read", 12'h500, 0);
    rd("R8 unmapped read", 12'h004, 0);
    wr(12'h600, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    rd("R8 ignored write", 12'h000, 32'h1DCB_A907);
    rd("R8 ignored write", 12'h080, 32'h00FF_FF00);

    tag = "R10";
    pin_in = 29'h1555_5555;
    bus_addr = 12'h100;
    @(negedge clk);
    @(negedge clk);
    check("R10 one edge early", bus_rdata, 0);
    @(negedge clk);
    check("R10 pin readback", bus_rdata, 32'h1555_5555);

    tag = "R11";
    bus_addr = 12'h000; bus_we = 1'b1; bus_wdata = 32'h0000_0ABC;
    @(negedge clk);
    bus_we = 1'b0;
    check("R11 read before write", bus_rdata, 32'h1DCB_A907);
    @(negedge clk);
    check("R11 read after write", bus_rdata, 32'h0000_0ABC);

    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      bus_addr  = 12'($urandom_range(0, 19) * 32'h40 + $urandom_range(0, 3));
      bus_we    = $urandom_range(0, 2) != 0;
      bus_wdata = $urandom;
      pin_in    = PN'($urandom);
      @(negedge clk);
      check("R9 reserved bits", bus_rdata & ~MASK, 0);
    end
    bus_we = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule